// File: doc/BRIEF.md
# External Request Edge Capture and DMA/Interrupt Router

This block watches sixteen external request pins. Each pin is brought into the clock domain through two flops. The block then looks for the edge direction chosen for that pin: rising, falling or both. A detected edge sets a sticky per-channel flag. Each flag can be passed on as an interrupt request or as a DMA request, under per-channel enable and steering bits. A DMA engine acknowledges a request by pulsing the channel's done input, and that pulse clears the flag in hardware.

A new edge that arrives while the channel's flag is still set is recorded as an overrun. The enabled overrun bits are ORed into a single overrun interrupt. Software controls all of this through a small 32-bit register port with a combinational read path.

If every request enable is left clear, the block acts as a plain edge-capture unit. Software polls the flag register to see which pins have seen their selected edge.

Top module: `ext_req_ctrl`

## Requirements
- R1: After reset every register reads zero and `dma_req`, `irq_req` and `ovr_irq` are all low.
- R2: A rising pin change on a channel whose rising-edge enable bit is set sets its flag bit on the third rising clock edge after the change, and not earlier. A pin change whose direction is not enabled leaves the flag unchanged.
- R3: The falling-edge enable register selects falling edges in the same way. A channel with both enables set counts either direction. A channel with only the rising enable set ignores a falling change.
- R4: `dma_req[i]` is high exactly when flag, request enable and steering bit i are all 1.
- R5: `irq_req[i]` is high exactly when flag and request enable bit i are 1 and steering bit i is 0.
- R6: A one-cycle pulse on `dma_done[i]` clears flag bit i on that clock edge. If an edge is detected on the same edge, the flag stays set.
- R7: Writing 1 to a bit of the flag register (offset 0x14) or the overrun register (offset 0x20) clears that bit, and writing 0 has no effect. A hardware set in the same cycle as a software clear wins.
- R8: An enabled edge detected while the channel's flag is already 1 sets the channel's overrun bit. An edge on a clear flag does not.
- R9: `ovr_irq` is the OR over all channels of overrun bit AND overrun enable bit (offset 0x24).
- R10: The register offsets are: flag 0x14, request enable 0x18, steering 0x1C, overrun 0x20, overrun enable 0x24, rising enable 0x28, falling enable 0x2C. Only bits 15:0 exist. Bits 31:16 read as 0 and ignore writes. Any other offset reads 0.
- R11: With all request enables clear, both request outputs stay low while the flag register still records edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_pin | input | 16 | External request pins, asynchronous |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 8 | Register byte offset for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| dma_done | input | 16 | Per-channel DMA acknowledge pulses |
| dma_req | output | 16 | Per-channel DMA requests |
| irq_req | output | 16 | Per-channel interrupt requests |
| ovr_irq | output | 1 | Combined overrun interrupt |

## Verification
A pin change reaches the flag and overrun registers on the third rising clock edge after it is driven, so the bench steps exactly two edges to confirm that the flag is still clear, then one more to confirm that it is set. Register writes and done pulses take effect on the edge that samples them. The request outputs and `ovr_irq` follow the registers with no further delay and are checked right after that edge. To test set-versus-clear, the bench places the done pulse or the clear write on the third edge, the one where the detected edge lands. Every comparison is made at the falling clock edge, away from the edges where inputs are driven.

// File: rtl/erc_pkg.sv
package erc_pkg;
    localparam int unsigned OFF_FLAG    = 'h14;
    localparam int unsigned OFF_REQ_EN  = 'h18;
    localparam int unsigned OFF_STEER   = 'h1C;
    localparam int unsigned OFF_OVR     = 'h20;
    localparam int unsigned OFF_OVR_EN  = 'h24;
    localparam int unsigned OFF_RISE_EN = 'h28;
    localparam int unsigned OFF_FALL_EN = 'h2C;
endpackage

// File: rtl/erc_edge_detect.sv
module erc_edge_detect #(
    parameter int N_CH = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] pin,
    input  logic [N_CH-1:0] rise_en,
    input  logic [N_CH-1:0] fall_en,
    output logic [N_CH-1:0] edge_hit
);
    typedef struct packed {
        logic [N_CH-1:0] s1;
        logic [N_CH-1:0] s2;
        logic [N_CH-1:0] prev;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d      = sy_q;
        sy_d.s1   = pin;
        sy_d.s2   = sy_q.s1;
        sy_d.prev = sy_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy_q <= '0;
        else        sy_q <= sy_d;
    end

    assign edge_hit = (sy_q.s2 & ~sy_q.prev & rise_en) |
                      (~sy_q.s2 & sy_q.prev & fall_en);
endmodule

// File: rtl/erc_reg_file.sv
module erc_reg_file
    import erc_pkg::*;
#(
    parameter int N_CH   = 16,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [N_CH-1:0]   edge_hit,
    input  logic [N_CH-1:0]   dma_done,
    output logic [N_CH-1:0]   flag_o,
    output logic [N_CH-1:0]   ovr_o,
    output logic [N_CH-1:0]   req_en_o,
    output logic [N_CH-1:0]   steer_o,
    output logic [N_CH-1:0]   ovr_en_o,
    output logic [N_CH-1:0]   rise_en_o,
    output logic [N_CH-1:0]   fall_en_o
);
    typedef struct packed {
        logic [N_CH-1:0] flag;
        logic [N_CH-1:0] ovr;
        logic [N_CH-1:0] req_en;
        logic [N_CH-1:0] steer;
        logic [N_CH-1:0] ovr_en;
        logic [N_CH-1:0] rise_en;
        logic [N_CH-1:0] fall_en;
    } regs_t;

    regs_t rg_d, rg_q;
    logic [N_CH-1:0] wval;
    logic wr_flag, wr_req_en, wr_steer, wr_ovr, wr_ovr_en, wr_rise, wr_fall;

    assign wval      = bus_wdata[N_CH-1:0];
    assign wr_flag   = bus_wr && (bus_addr == ADDR_W'(OFF_FLAG));
    assign wr_req_en = bus_wr && (bus_addr == ADDR_W'(OFF_REQ_EN));
    assign wr_steer  = bus_wr && (bus_addr == ADDR_W'(OFF_STEER));
    assign wr_ovr    = bus_wr && (bus_addr == ADDR_W'(OFF_OVR));
    assign wr_ovr_en = bus_wr && (bus_addr == ADDR_W'(OFF_OVR_EN));
    assign wr_rise   = bus_wr && (bus_addr == ADDR_W'(OFF_RISE_EN));
    assign wr_fall   = bus_wr && (bus_addr == ADDR_W'(OFF_FALL_EN));

    always_comb begin
        logic [N_CH-1:0] flag_clr;
        logic [N_CH-1:0] ovr_clr;
        rg_d     = rg_q;
        flag_clr = dma_done | (wr_flag ? wval : '0);
        ovr_clr  = wr_ovr ? wval : '0;
        // hardware set wins over any clear in the same cycle
        rg_d.flag = (rg_q.flag & ~flag_clr) | edge_hit;
        rg_d.ovr  = (rg_q.ovr & ~ovr_clr) | (edge_hit & rg_q.flag);
        if (wr_req_en) rg_d.req_en  = wval;
        if (wr_steer)  rg_d.steer   = wval;
        if (wr_ovr_en) rg_d.ovr_en  = wval;
        if (wr_rise)   rg_d.rise_en = wval;
        if (wr_fall)   rg_d.fall_en = wval;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(OFF_FLAG):    bus_rdata[N_CH-1:0] = rg_q.flag;
            ADDR_W'(OFF_REQ_EN):  bus_rdata[N_CH-1:0] = rg_q.req_en;
            ADDR_W'(OFF_STEER):   bus_rdata[N_CH-1:0] = rg_q.steer;
            ADDR_W'(OFF_OVR):     bus_rdata[N_CH-1:0] = rg_q.ovr;
            ADDR_W'(OFF_OVR_EN):  bus_rdata[N_CH-1:0] = rg_q.ovr_en;
            ADDR_W'(OFF_RISE_EN): bus_rdata[N_CH-1:0] = rg_q.rise_en;
            ADDR_W'(OFF_FALL_EN): bus_rdata[N_CH-1:0] = rg_q.fall_en;
            default:              bus_rdata = '0;
        endcase
    end

    assign flag_o    = rg_q.flag;
    assign ovr_o     = rg_q.ovr;
    assign req_en_o  = rg_q.req_en;
    assign steer_o   = rg_q.steer;
    assign ovr_en_o  = rg_q.ovr_en;
    assign rise_en_o = rg_q.rise_en;
    assign fall_en_o = rg_q.fall_en;
endmodule

// File: rtl/erc_req_route.sv
module erc_req_route #(
    parameter int N_CH = 16
) (
    input  logic [N_CH-1:0] flag,
    input  logic [N_CH-1:0] req_en,
    input  logic [N_CH-1:0] steer,
    input  logic [N_CH-1:0] ovr,
    input  logic [N_CH-1:0] ovr_en,
    output logic [N_CH-1:0] dma_req,
    output logic [N_CH-1:0] irq_req,
    output logic            ovr_irq
);
    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        logic active;
        assign active     = flag[i] & req_en[i];
        assign dma_req[i] = active & steer[i];
        assign irq_req[i] = active & ~steer[i];
    end

    assign ovr_irq = |(ovr & ovr_en);
endmodule

// File: rtl/ext_req_ctrl.sv
module ext_req_ctrl #(
    parameter int N_CH   = 16,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_CH-1:0]   req_pin,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [N_CH-1:0]   dma_done,
    output logic [N_CH-1:0]   dma_req,
    output logic [N_CH-1:0]   irq_req,
    output logic              ovr_irq
);
    logic [N_CH-1:0] edge_hit;
    logic [N_CH-1:0] flag_vec, ovr_vec, req_en, steer, ovr_en, rise_en, fall_en;

    erc_edge_detect #(.N_CH(N_CH)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin      (req_pin),
        .rise_en  (rise_en),
        .fall_en  (fall_en),
        .edge_hit (edge_hit)
    );

    erc_reg_file #(.N_CH(N_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .edge_hit  (edge_hit),
        .dma_done  (dma_done),
        .flag_o    (flag_vec),
        .ovr_o     (ovr_vec),
        .req_en_o  (req_en),
        .steer_o   (steer),
        .ovr_en_o  (ovr_en),
        .rise_en_o (rise_en),
        .fall_en_o (fall_en)
    );

    erc_req_route #(.N_CH(N_CH)) u_route (
        .flag    (flag_vec),
        .req_en  (req_en),
        .steer   (steer),
        .ovr     (ovr_vec),
        .ovr_en  (ovr_en),
        .dma_req (dma_req),
        .irq_req (irq_req),
        .ovr_irq (ovr_irq)
    );
endmodule

// File: rtl/erc_checker.sv
module erc_checker #(
    parameter int N_CH   = 16,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_CH-1:0]   dma_req,
    input logic [N_CH-1:0]   irq_req,
    input logic              ovr_irq,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [N_CH-1:0]   dma_done,
    input logic [N_CH-1:0]   flag_vec,
    input logic [N_CH-1:0]   ovr_vec,
    input logic [N_CH-1:0]   edge_hit
);
    AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req & irq_req) == '0); // R4

    AST_REQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        ((dma_req | irq_req) & ~flag_vec) == '0); // R5

    AST_EDGE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_hit != '0) |=> ((flag_vec & $past(edge_hit)) == $past(edge_hit))); // R6

    AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ((dma_done & ~edge_hit) != '0) |=> ((flag_vec & $past(dma_done & ~edge_hit)) == '0)); // R6

    AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ((edge_hit & flag_vec) != '0) |=> ((ovr_vec & $past(edge_hit & flag_vec)) == $past(edge_hit & flag_vec))); // R8

    AST_OVR_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_irq |-> (ovr_vec != '0)); // R9

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DATA_W-1:N_CH] == '0); // R10
endmodule

bind ext_req_ctrl erc_checker #(.N_CH(N_CH), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dma_req   (dma_req),
    .irq_req   (irq_req),
    .ovr_irq   (ovr_irq),
    .bus_rdata (bus_rdata),
    .dma_done  (dma_done),
    .flag_vec  (flag_vec),
    .ovr_vec   (ovr_vec),
    .edge_hit  (edge_hit)
);

// File: tb/tb_ext_req_ctrl.sv
module tb_ext_req_ctrl;
    localparam int N_CH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] req_pin = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] dma_done = '0;
    logic [15:0] dma_req;
    logic [15:0] irq_req;
    logic        ovr_irq;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    typedef struct {
        int          kind;   // 0 register read, 1 dma_req, 2 irq_req, 3 ovr_irq
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    always #5 clk = ~clk;

    ext_req_ctrl dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_pin   (req_pin),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .dma_done  (dma_done),
        .dma_req   (dma_req),
        .irq_req   (irq_req),
        .ovr_irq   (ovr_irq)
    );

    // monitor: pops one expected item per falling edge and compares
    always @(negedge clk) begin
        if (sb.size() != 0) begin
            item_t it;
            logic [31:0] act;
            it = sb.pop_front();
            case (it.kind)
                0:       act = bus_rdata;
                1:       act = {16'h0, dma_req};
                2:       act = {16'h0, irq_req};
                default: act = {31'h0, ovr_irq};
            endcase
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1;
        bus_addr = a;
        bus_wdata = d;
        step();
        bus_wr = 1'b0;
    endtask

    task automatic exp_reg(input logic [7:0] a, input logic [31:0] e, input string tag);
        bus_addr = a;
        sb.push_back('{0, e, tag});
        @(negedge clk);
        #1;
    endtask

    task automatic exp_port(input int k, input logic [31:0] e, input string tag);
        sb.push_back('{k, e, tag});
        @(negedge clk);
        #1;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        steps(3);
        rst_n = 1'b1;
        step();

        // R1 reset state
        for (int a = 'h14; a <= 'h2C; a += 4)
            exp_reg(8'(a), 32'h0, "R1 register reset");
        exp_port(1, 32'h0, "R1 dma_req reset");
        exp_port(2, 32'h0, "R1 irq_req reset");
        exp_port(3, 32'h0, "R1 ovr_irq reset");

        // R10 offsets and upper bits
        wr(8'h28, 32'hFFFF_0003);
        wr(8'h2C, 32'h0000_0002);
        exp_reg(8'h28, 32'h0000_0003, "R10 rising enable upper ignored");
        exp_reg(8'h2C, 32'h0000_0002, "R10 falling enable");
        exp_reg(8'h30, 32'h0, "R10 unmapped offset");

        // R2 rising edge latency, R11 pure capture
        req_pin[0] = 1'b1;
        steps(2);
        exp_reg(8'h14, 32'h0, "R2 flag not yet set");
        step();
        exp_reg(8'h14, 32'h1, "R2 flag set on third edge");
        exp_port(1, 32'h0, "R11 dma_req low in capture mode");
        exp_port(2, 32'h0, "R11 irq_req low in capture mode");

        req_pin[2] = 1'b1;
        steps(3);
        exp_reg(8'h14, 32'h1, "R2 disabled channel ignored");

        // R3 both-edge channel
        req_pin[1] = 1'b1;
        steps(3);
        exp_reg(8'h14, 32'h3, "R3 rising on both-edge channel");
        req_pin[1] = 1'b0;
        steps(3);
        exp_reg(8'h20, 32'h2, "R8 overrun on set flag");
        req_pin[0] = 1'b0;
        steps(3);
        exp_reg(8'h20, 32'h2, "R3 falling ignored on rise-only channel");

        // R7 write-one-to-clear
        wr(8'h14, 32'h1);
        exp_reg(8'h14, 32'h2, "R7 flag write one clears");
        wr(8'h14, 32'h0);
        exp_reg(8'h14, 32'h2, "R7 flag write zero no effect");
        wr(8'h20, 32'h2);
        exp_reg(8'h20, 32'h0, "R7 overrun write one clears");

        // R9 overrun interrupt
        req_pin[1] = 1'b1;
        steps(3);
        exp_reg(8'h20, 32'h2, "R8 second overrun");
        exp_port(3, 32'h0, "R9 ovr_irq masked");
        wr(8'h24, 32'h2);
        exp_port(3, 32'h1, "R9 ovr_irq enabled");
        wr(8'h24, 32'h1);
        exp_port(3, 32'h0, "R9 ovr_irq other bit enabled");
        wr(8'h20, 32'hFFFF);

        // R5 / R4 routing
        wr(8'h18, 32'h2);
        exp_port(2, 32'h2, "R5 irq_req when steer clear");
        exp_port(1, 32'h0, "R5 dma_req low when steer clear");
        wr(8'h1C, 32'h2);
        exp_port(1, 32'h2, "R4 dma_req when steer set");
        exp_port(2, 32'h0, "R4 irq_req low when steer set");

        // R6 done clears
        dma_done[1] = 1'b1;
        step();
        dma_done[1] = 1'b0;
        exp_reg(8'h14, 32'h0, "R6 done clears flag");
        exp_port(1, 32'h0, "R6 dma_req drops after done");

        // R6 set wins over done
        req_pin[1] = 1'b0;
        steps(2);
        dma_done[1] = 1'b1;
        step();
        dma_done[1] = 1'b0;
        exp_reg(8'h14, 32'h2, "R6 edge wins over done");
        exp_reg(8'h20, 32'h0, "R8 no overrun on clear flag");

        // R7 set wins over software clear
        wr(8'h14, 32'h2);
        exp_reg(8'h14, 32'h0, "R7 flag cleared before race");
        req_pin[1] = 1'b1;
        steps(2);
        wr(8'h14, 32'h2);
        exp_reg(8'h14, 32'h2, "R7 edge wins over write clear");

        // R11 disable requests again
        wr(8'h18, 32'h0);
        exp_port(1, 32'h0, "R11 dma_req low after disable");
        exp_reg(8'h14, 32'h2, "R11 flag retained when disabled");

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule